// File: doc/BRIEF.md
# NVRAM Partition Header Scanner

This block finds three partitions inside an 8 KiB non-volatile memory. The memory is laid out as a chain of 16-byte headers. Each header holds a big-endian length, counted in 16-byte units, and a 12-byte name. After a start pulse, the scanner walks the chain through a single byte-wide memory port. It compares each name against two fixed strings and records where the matching partitions begin.

When the partition-table mode input is low, no memory is read. The three offsets are set to fixed legacy values instead.

After a scan, a small window port gives indexed byte access into the second partition. Each access is checked against a bound. Refused reads answer 0xFF and refused writes are dropped.

The memory request port and the window request port both use a valid/ready handshake. A requester that raises valid must keep valid and its payload steady until it sees ready high at a clock edge. Ready may stay low for any number of cycles. The scanner and the window take turns on the one memory port. Read responses arrive as a one-cycle valid pulse, in request order, and cannot be stalled.

Top module: `nv_part_scan`

## Requirements
- R1: After reset, `scan_busy` and `scan_done` are low, every `partN_vld` is low, and every `partN_off` is all ones (14 bits, 0x3FFF).
- R2: With `table_mode` high, a scan reads bytes 0 to 15 of each header, in that order, at the header offset plus the byte number, modulo 0x2000. Byte 2 is the high byte and byte 3 the low byte of the length L. The next header starts at the current offset plus L×16. The first header is at 0, and the scan ends once the next offset is 0x2000 or more.
- R3: A header whose length is zero is the last one read.
- R4: When the name field (bytes 4 to 15) matches "common", part0 becomes valid with offset header+0x10.
- R5: When the name field matches "APL,MacOS75", part1 becomes valid with offset header+0x10 and part2 becomes valid with offset header+0x110. When several headers match the same name, the one that comes later in the chain wins.
- R6: Names are compared as NUL-terminated strings. Name bytes after the first NUL that matches the expected string have no effect. Any byte that differs before that point rejects the match.
- R7: A partition whose name was never found in the scan has `vld` low and `off` equal to all ones. Accepting a start clears all three results to this state.
- R8: With `table_mode` low, an accepted start sets the offsets to 0x1800 (part0), 0x1300 (part1) and 0x1400 (part2), all valid. It issues no memory request, and `scan_done` pulses on the next cycle.
- R9: A window access with part1 valid and index 0 to 0x100 reaches address (part1 offset + index) modulo 0x2000. A read returns that byte on `win_rsp_*`, and a write stores `win_req_wdata` there.
- R10: A window access is refused when part1 is invalid or the index is above 0x100. A refused read returns 0xFF one cycle after acceptance, and a refused write makes no memory request.
- R11: A start is accepted only while both the scanner and the window are idle. A start raised while either is busy is ignored. If start and a window request come in the same cycle, the start wins and `win_req_ready` is low. The scanner and the window never own the memory port at the same time.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request (valid, address, write flag) is held unchanged into the next cycle.
- R13: `scan_done` is a one-cycle pulse that follows the last header evaluated. `scan_busy` is high from the cycle after an accepted table start until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_start | input | 1 | Start pulse for a scan or a default load |
| table_mode | input | 1 | 1: walk the header chain, 0: load fixed offsets |
| scan_busy | output | 1 | Header walk in progress |
| scan_done | output | 1 | One-cycle pulse when the results are final |
| part0_off | output | 14 | Offset of the "common" partition |
| part0_vld | output | 1 | part0 found |
| part1_off | output | 14 | Offset of the second partition |
| part1_vld | output | 1 | part1 found |
| part2_off | output | 14 | Offset of the third partition |
| part2_vld | output | 1 | part2 found |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1: write, 0: read |
| mem_req_addr | output | 13 | Byte address |
| mem_req_wdata | output | 8 | Write data |
| mem_rsp_valid | input | 1 | Read data valid pulse |
| mem_rsp_data | input | 8 | Read data |
| win_req_valid | input | 1 | Window request valid |
| win_req_ready | output | 1 | Window request accepted |
| win_req_we | input | 1 | 1: write, 0: read |
| win_req_idx | input | 10 | Byte index into part1 |
| win_req_wdata | input | 8 | Window write data |
| win_rsp_valid | output | 1 | Window read data valid pulse |
| win_rsp_data | output | 8 | Window read data |

## Verification
A start pulse and a window request can reach the block in the same cycle, and both want the single memory port. The bench raises both together while everything is idle. It checks that `win_req_ready` stays low, that a scan begins, and that the held window read is served only after `scan_done`, from the partition offset found by the new scan. Starts raised again during a running scan are also checked to be ignored: the bench counts the memory reads and the `scan_done` pulses.

// File: rtl/nv_scan_pkg.sv
package nv_scan_pkg;

  localparam int NAME_BYTES = 12;
  localparam int HDR_BYTES  = 16;
  localparam int NAME_POS   = 4;
  localparam int LEN_HI_POS = 2;
  localparam int LEN_LO_POS = 3;

  typedef enum logic [1:0] {WK_IDLE, WK_REQ, WK_WAIT, WK_EVAL} walk_st_e;
  typedef enum logic [1:0] {WN_IDLE, WN_REQ, WN_WAIT} win_st_e;

  // A string literal in a vector is right-aligned; return character k
  // counted from the first (leftmost non-zero) character, 0 past the end.
  function automatic logic [7:0] nv_name_char(input logic [8*NAME_BYTES-1:0] s,
                                              input int k);
    int  lead;
    int  pos;
    bit  seen;
    lead = 0;
    seen = 1'b0;
    for (int j = NAME_BYTES - 1; j >= 0; j--) begin
      if (!seen) begin
        if (s[j*8 +: 8] == 8'h00) lead++;
        else seen = 1'b1;
      end
    end
    pos = NAME_BYTES - 1 - lead - k;
    if (pos < 0 || k >= NAME_BYTES) return 8'h00;
    return s[pos*8 +: 8];
  endfunction

endpackage

// File: rtl/nv_name_match.sv
module nv_name_match
  import nv_scan_pkg::*;
#(
  parameter logic [8*NAME_BYTES-1:0] NAME = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [3:0] idx,
  input  logic [7:0] data,
  output logic       hit
);

  logic [7:0] exp_tab [16];
  logic       live;
  logic       ended;

  for (genvar k = 0; k < 16; k++) begin : g_exp
    localparam logic [7:0] EXP_CH = nv_name_char(NAME, k);
    assign exp_tab[k] = EXP_CH;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live  <= 1'b1;
      ended <= 1'b0;
    end else if (clr) begin
      live  <= 1'b1;
      ended <= 1'b0;
    end else if (en && !ended) begin
      if (data != exp_tab[idx]) begin
        live  <= 1'b0;
        ended <= 1'b1;
      end else if (data == 8'h00) begin
        ended <= 1'b1;
      end
    end
  end

  assign hit = live;

  // R6: once the comparison has ended, later name bytes cannot reopen it
  a_r6_ended_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ended && !clr) |=> ended);

endmodule

// File: rtl/nv_hdr_walker.sv
module nv_hdr_walker
  import nv_scan_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int OFF_W  = ADDR_W + 1,
  parameter int DEF0   = 'h1800,
  parameter int DEF1   = 'h1300,
  parameter int DEF2   = 'h1400,
  parameter int XOFF   = 'h110,
  parameter logic [8*NAME_BYTES-1:0] NAME0 = "common",
  parameter logic [8*NAME_BYTES-1:0] NAME1 = "APL,MacOS75"
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic              table_mode,
  output logic              busy,
  output logic              done,
  output logic [OFF_W-1:0]  p0_off,
  output logic              p0_vld,
  output logic [OFF_W-1:0]  p1_off,
  output logic              p1_vld,
  output logic [OFF_W-1:0]  p2_off,
  output logic              p2_vld,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data
);

  localparam int SUM_W = ((ADDR_W > 20) ? ADDR_W : 20) + 1;
  localparam logic [OFF_W-1:0] INV = '1;

  walk_st_e          st;
  logic [ADDR_W-1:0] hdr_off;
  logic [3:0]        byte_i;
  logic [15:0]       len_q;
  logic              done_q;
  logic [1:0]        hit;
  logic              m_clr;
  logic              m_en;
  logic [3:0]        m_idx;
  logic [SUM_W-1:0]  next_sum;
  logic              stop;

  assign next_sum = SUM_W'(hdr_off) + (SUM_W'(len_q) << 4);
  assign stop     = (len_q == 16'h0) || (next_sum[SUM_W-1:ADDR_W] != '0);

  assign m_clr = (st == WK_IDLE) || (st == WK_EVAL);
  assign m_en  = (st == WK_WAIT) && rsp_valid && (byte_i >= 4'(NAME_POS));
  assign m_idx = byte_i - 4'(NAME_POS);

  for (genvar g = 0; g < 2; g++) begin : g_match
    nv_name_match #(.NAME(g == 0 ? NAME0 : NAME1)) u_match (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (m_clr),
      .en   (m_en),
      .idx  (m_idx),
      .data (rsp_data),
      .hit  (hit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= WK_IDLE;
      hdr_off <= '0;
      byte_i  <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
      p0_off  <= INV;
      p1_off  <= INV;
      p2_off  <= INV;
      p0_vld  <= 1'b0;
      p1_vld  <= 1'b0;
      p2_vld  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        WK_IDLE: begin
          if (start_ok) begin
            if (!table_mode) begin
              p0_off <= OFF_W'(DEF0);
              p1_off <= OFF_W'(DEF1);
              p2_off <= OFF_W'(DEF2);
              p0_vld <= 1'b1;
              p1_vld <= 1'b1;
              p2_vld <= 1'b1;
              done_q <= 1'b1;
            end else begin
              p0_off  <= INV;
              p1_off  <= INV;
              p2_off  <= INV;
              p0_vld  <= 1'b0;
              p1_vld  <= 1'b0;
              p2_vld  <= 1'b0;
              hdr_off <= '0;
              byte_i  <= '0;
              st      <= WK_REQ;
            end
          end
        end
        WK_REQ: begin
          if (req_ready) st <= WK_WAIT;
        end
        WK_WAIT: begin
          if (rsp_valid) begin
            if (byte_i == 4'(LEN_HI_POS)) len_q[15:8] <= rsp_data;
            if (byte_i == 4'(LEN_LO_POS)) len_q[7:0]  <= rsp_data;
            if (byte_i == 4'(HDR_BYTES - 1)) begin
              st <= WK_EVAL;
            end else begin
              byte_i <= byte_i + 4'd1;
              st     <= WK_REQ;
            end
          end
        end
        WK_EVAL: begin
          if (hit[0]) begin
            p0_off <= OFF_W'(hdr_off) + OFF_W'(HDR_BYTES);
            p0_vld <= 1'b1;
          end
          if (hit[1]) begin
            p1_off <= OFF_W'(hdr_off) + OFF_W'(HDR_BYTES);
            p1_vld <= 1'b1;
            p2_off <= OFF_W'(hdr_off) + OFF_W'(XOFF);
            p2_vld <= 1'b1;
          end
          if (stop) begin
            st     <= WK_IDLE;
            done_q <= 1'b1;
          end else begin
            hdr_off <= next_sum[ADDR_W-1:0];
            byte_i  <= '0;
            st      <= WK_REQ;
          end
        end
        default: st <= WK_IDLE;
      endcase
    end
  end

  assign busy      = (st != WK_IDLE);
  assign done      = done_q;
  assign req_valid = (st == WK_REQ);
  assign req_addr  = hdr_off + ADDR_W'(byte_i);

  // R3: a zero length evaluates to the end of the walk
  a_r3_zero_len_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WK_EVAL && len_q == 16'h0) |=> (st == WK_IDLE && done));

  // R13: completion is only flagged from the idle state
  a_r13_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: a result is valid or it carries the all-ones marker
  a_r7_invalid_marker: assert property (@(posedge clk) disable iff (!rst_n)
    !p0_vld |-> (p0_off == INV));

endmodule

// File: rtl/nv_win_port.sv
module nv_win_port
  import nv_scan_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int OFF_W     = ADDR_W + 1,
  parameter int WIN_IW    = 10,
  parameter int WIN_LIMIT = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allow,
  input  logic [OFF_W-1:0]  p1_off,
  input  logic              p1_vld,
  output logic              busy,
  input  logic              win_req_valid,
  output logic              win_req_ready,
  input  logic              win_req_we,
  input  logic [WIN_IW-1:0] win_req_idx,
  input  logic [7:0]        win_req_wdata,
  output logic              win_rsp_valid,
  output logic [7:0]        win_rsp_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [7:0]        m_wdata,
  input  logic              m_rsp_valid,
  input  logic [7:0]        m_rsp_data
);

  localparam int SUM_W = ((OFF_W > WIN_IW) ? OFF_W : WIN_IW) + 1;

  win_st_e           st;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic [WIN_IW-1:0] idx_q;
  logic              rsp_v_q;
  logic [7:0]        rsp_d_q;
  logic              refuse;
  logic [SUM_W-1:0]  sum;

  assign refuse = !p1_vld || (SUM_W'(win_req_idx) > SUM_W'(WIN_LIMIT));
  assign sum    = SUM_W'(p1_off) + SUM_W'(win_req_idx);

  assign win_req_ready = allow && (st == WN_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= WN_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      idx_q   <= '0;
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      case (st)
        WN_IDLE: begin
          if (win_req_valid && win_req_ready) begin
            if (refuse) begin
              if (!win_req_we) begin
                rsp_v_q <= 1'b1;
                rsp_d_q <= 8'hFF;
              end
            end else begin
              we_q    <= win_req_we;
              addr_q  <= sum[ADDR_W-1:0];
              wdata_q <= win_req_wdata;
              idx_q   <= win_req_idx;
              st      <= WN_REQ;
            end
          end
        end
        WN_REQ: begin
          if (m_ready) st <= we_q ? WN_IDLE : WN_WAIT;
        end
        WN_WAIT: begin
          if (m_rsp_valid) begin
            rsp_v_q <= 1'b1;
            rsp_d_q <= m_rsp_data;
            st      <= WN_IDLE;
          end
        end
        default: st <= WN_IDLE;
      endcase
    end
  end

  assign busy          = (st != WN_IDLE);
  assign m_valid       = (st == WN_REQ);
  assign m_we          = we_q;
  assign m_addr        = addr_q;
  assign m_wdata       = wdata_q;
  assign win_rsp_valid = rsp_v_q;
  assign win_rsp_data  = rsp_d_q;

  // R10: only in-bound accesses to a valid partition reach memory
  a_r10_refused_stays_off_bus: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (p1_vld && SUM_W'(idx_q) <= SUM_W'(WIN_LIMIT)));

  // R12: a stalled window request keeps its payload
  a_r12_win_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_we)));

endmodule

// File: rtl/nv_part_scan.sv
module nv_part_scan
  import nv_scan_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int WIN_IW    = 10,
  parameter int WIN_LIMIT = 'h100,
  parameter int DEF0      = 'h1800,
  parameter int DEF1      = 'h1300,
  parameter int DEF2      = 'h1400,
  parameter int XOFF      = 'h110,
  parameter int OFF_W     = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_start,
  input  logic              table_mode,
  output logic              scan_busy,
  output logic              scan_done,
  output logic [OFF_W-1:0]  part0_off,
  output logic              part0_vld,
  output logic [OFF_W-1:0]  part1_off,
  output logic              part1_vld,
  output logic [OFF_W-1:0]  part2_off,
  output logic              part2_vld,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  input  logic              win_req_valid,
  output logic              win_req_ready,
  input  logic              win_req_we,
  input  logic [WIN_IW-1:0] win_req_idx,
  input  logic [7:0]        win_req_wdata,
  output logic              win_rsp_valid,
  output logic [7:0]        win_rsp_data
);

  logic              wk_busy;
  logic              wk_req_valid;
  logic [ADDR_W-1:0] wk_req_addr;
  logic              wn_busy;
  logic              wn_valid;
  logic              wn_we;
  logic [ADDR_W-1:0] wn_addr;
  logic [7:0]        wn_wdata;
  logic              start_ok;
  logic              win_allow;

  assign start_ok  = scan_start && !wn_busy;
  assign win_allow = !wk_busy && !scan_start;

  nv_hdr_walker #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DEF0(DEF0), .DEF1(DEF1), .DEF2(DEF2), .XOFF(XOFF)
  ) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (start_ok),
    .table_mode(table_mode),
    .busy      (wk_busy),
    .done      (scan_done),
    .p0_off    (part0_off),
    .p0_vld    (part0_vld),
    .p1_off    (part1_off),
    .p1_vld    (part1_vld),
    .p2_off    (part2_off),
    .p2_vld    (part2_vld),
    .req_valid (wk_req_valid),
    .req_ready (mem_req_ready),
    .req_addr  (wk_req_addr),
    .rsp_valid (mem_rsp_valid),
    .rsp_data  (mem_rsp_data)
  );

  nv_win_port #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WIN_IW(WIN_IW), .WIN_LIMIT(WIN_LIMIT)
  ) u_win (
    .clk          (clk),
    .rst_n        (rst_n),
    .allow        (win_allow),
    .p1_off       (part1_off),
    .p1_vld       (part1_vld),
    .busy         (wn_busy),
    .win_req_valid(win_req_valid),
    .win_req_ready(win_req_ready),
    .win_req_we   (win_req_we),
    .win_req_idx  (win_req_idx),
    .win_req_wdata(win_req_wdata),
    .win_rsp_valid(win_rsp_valid),
    .win_rsp_data (win_rsp_data),
    .m_valid      (wn_valid),
    .m_ready      (mem_req_ready && !wk_busy),
    .m_we         (wn_we),
    .m_addr       (wn_addr),
    .m_wdata      (wn_wdata),
    .m_rsp_valid  (mem_rsp_valid),
    .m_rsp_data   (mem_rsp_data)
  );

  always_comb begin
    if (wk_busy) begin
      mem_req_valid = wk_req_valid;
      mem_req_we    = 1'b0;
      mem_req_addr  = wk_req_addr;
      mem_req_wdata = 8'h00;
    end else begin
      mem_req_valid = wn_valid;
      mem_req_we    = wn_we;
      mem_req_addr  = wn_addr;
      mem_req_wdata = wn_wdata;
    end
  end

  assign scan_busy = wk_busy;

  // R11: scanner and window never hold the memory port together
  a_r11_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wk_busy, wn_busy}));

  // R12: a stalled memory request is held unchanged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

  // R8: the memory port stays quiet in the cycle a default load completes
  a_r8_defaults_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && !wk_busy && !table_mode) |=> !mem_req_valid);

endmodule

// File: tb/test_nv_part_scan.sv
module test_nv_part_scan;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 8192;
  localparam int MASK       = MEM_BYTES - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_start = 1'b0;
  logic        table_mode = 1'b1;
  logic        scan_busy, scan_done;
  logic [13:0] part0_off, part1_off, part2_off;
  logic        part0_vld, part1_vld, part2_vld;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b1;
  logic [12:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = 8'h00;
  logic        win_req_valid = 1'b0;
  logic        win_req_ready;
  logic        win_req_we = 1'b0;
  logic [9:0]  win_req_idx = '0;
  logic [7:0]  win_req_wdata = '0;
  logic        win_rsp_valid;
  logic [7:0]  win_rsp_data;

  int checks = 0;
  int errors = 0;
  int rd_count = 0;
  int wr_count = 0;
  int done_count = 0;
  int cyc = 0;

  logic [7:0] mem [0:MEM_BYTES-1];
  logic       build_req = 1'b0;
  int         build_mode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nv_part_scan i_nv_part_scan (
    .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .table_mode(table_mode),
    .scan_busy(scan_busy), .scan_done(scan_done),
    .part0_off(part0_off), .part0_vld(part0_vld),
    .part1_off(part1_off), .part1_vld(part1_vld),
    .part2_off(part2_off), .part2_vld(part2_vld),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .win_req_valid(win_req_valid), .win_req_ready(win_req_ready),
    .win_req_we(win_req_we), .win_req_idx(win_req_idx),
    .win_req_wdata(win_req_wdata), .win_rsp_valid(win_rsp_valid),
    .win_rsp_data(win_rsp_data)
  );

  // ---------------- image construction (runs inside the memory process)
  task automatic put_name(input int off, input string s, input bit term);
    for (int k = 0; k < s.len(); k++) mem[(off + 4 + k) & MASK] = s[k];
    if (term && s.len() < 12) mem[(off + 4 + s.len()) & MASK] = 8'h00;
  endtask

  task automatic put_hdr(input int off, input int len, input int kind);
    mem[off & MASK]       = 8'h5a;
    mem[(off + 2) & MASK] = len[15:8];
    mem[(off + 3) & MASK] = len[7:0];
    case (kind)
      0: put_name(off, "common", 1'b1);
      1: put_name(off, "APL,MacOS75", 1'b1);
      2: put_name(off, "commoX", 1'b1);
      3: put_name(off, "APL,MacOS7", 1'b1);
      4: put_name(off, "commonQ", 1'b1);
      default: put_name(off, "zzzz", 1'b1);
    endcase
  endtask

  task automatic build_image(input int mode);
    int off, len, r, n;
    for (int a = 0; a < MEM_BYTES; a++) begin
      mem[a] = 8'($urandom);
      if (mem[a] == 8'h00) mem[a] = 8'h41;
    end
    case (mode)
      1: begin
        put_hdr(0, 3, 0);
        put_hdr('h30, 'h20, 1);
        put_hdr('h230, 0, 2);
      end
      2: begin
        put_hdr(0, 'h100, 5);
        put_hdr('h1000, 'h100, 4);
      end
      3: begin
        put_hdr(0, 2, 1);
        put_hdr('h20, 'h1FD, 0);
        put_hdr('h1FF0, 1, 1);
      end
      default: begin
        off = 0; n = 0;
        while (off < MEM_BYTES && n < 30) begin
          r = $urandom % 16;
          if (r == 0) len = 0;
          else if (r == 1) len = 'h100 + $urandom % 'h200;
          else len = 1 + $urandom % 40;
          put_hdr(off, len, $urandom % 7);
          n++;
          if (len == 0) break;
          off += len * 16;
        end
      end
    endcase
  endtask

  // ---------------- memory model, one-cycle read latency, random stalls
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (build_req) begin
      build_image(build_mode);
    end else if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr] <= mem_req_wdata;
        wr_count <= wr_count + 1;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr];
        rd_count <= rd_count + 1;
      end
    end
    if (scan_done) done_count <= done_count + 1;
  end

  always @(negedge clk) mem_req_ready <= ($urandom % 4) != 0;

  // ---------------- reference model
  function automatic bit ref_match(input int off, input string s);
    logic [7:0] e, b;
    for (int k = 0; k < 12; k++) begin
      e = (k < s.len()) ? s[k] : 8'h00;
      b = mem[(off + 4 + k) & MASK];
      if (b != e) return 1'b0;
      if (b == 8'h00) return 1'b1;
    end
    return 1'b1;
  endfunction

  int e_off0, e_off1, e_off2, e_hdrs;
  bit e_v0, e_v1, e_v2;

  task automatic ref_walk();
    int off, len;
    e_v0 = 0; e_v1 = 0; e_v2 = 0;
    e_off0 = 'h3FFF; e_off1 = 'h3FFF; e_off2 = 'h3FFF;
    e_hdrs = 0; off = 0;
    do begin
      e_hdrs++;
      if (ref_match(off, "common")) begin e_v0 = 1; e_off0 = off + 'h10; end
      if (ref_match(off, "APL,MacOS75")) begin
        e_v1 = 1; e_off1 = off + 'h10; e_v2 = 1; e_off2 = off + 'h110;
      end
      len = {mem[(off + 2) & MASK], mem[(off + 3) & MASK]};
      if (len == 0) break;
      off += len * 16;
    end while (off < MEM_BYTES);
  endtask

  // ---------------- helpers
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic load(input int mode);
    @(negedge clk); build_mode = mode; build_req = 1'b1;
    @(negedge clk); build_req = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!scan_done && n < 30000) begin @(negedge clk); n++; end
  endtask

  task automatic do_scan(input bit mode);
    @(negedge clk); table_mode = mode; scan_start = 1'b1;
    @(negedge clk); scan_start = 1'b0;
    wait_done();
  endtask

  task automatic check_results(input string tag);
    chk(part0_vld == e_v0 && part0_off == 14'(e_off0), {tag, " R4 part0"}, part0_off, e_off0);
    chk(part1_vld == e_v1 && part1_off == 14'(e_off1), {tag, " R5 part1"}, part1_off, e_off1);
    chk(part2_vld == e_v2 && part2_off == 14'(e_off2), {tag, " R5 part2"}, part2_off, e_off2);
  endtask

  task automatic win_op(input bit we, input int idx, input logic [7:0] wd,
                        output logic [7:0] rd);
    int n = 0;
    @(negedge clk);
    win_req_valid = 1'b1; win_req_we = we; win_req_idx = 10'(idx); win_req_wdata = wd;
    #1;
    while (!win_req_ready && n < 30000) begin @(negedge clk); #1; n++; end
    @(negedge clk);
    win_req_valid = 1'b0;
    rd = 8'hxx;
    if (!we) begin
      n = 0;
      while (!win_rsp_valid && n < 50) begin @(negedge clk); n++; end
      rd = win_rsp_data;
    end else begin
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic win_check(input bit we, input int idx, input string tag);
    logic [7:0] rd, wd, expv;
    int a, wc;
    bit refused;
    refused = !part1_vld || idx > 'h100;
    a = (int'(part1_off) + idx) & MASK;
    wd = 8'($urandom);
    wc = wr_count;
    if (we) begin
      win_op(1'b1, idx, wd, rd);
      if (refused) chk(wr_count == wc, {tag, " R10 dropped write"}, wr_count, wc);
      else chk(mem[a] == wd && wr_count == wc + 1, {tag, " R9 write"}, mem[a], wd);
    end else begin
      expv = refused ? 8'hFF : mem[a];
      win_op(1'b0, idx, 8'h00, rd);
      chk(rd === expv, refused ? {tag, " R10 refused read"} : {tag, " R9 read"}, rd, expv);
    end
  endtask

  // ---------------- watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog R13 actual=%0d expected<190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus
  initial begin
    int rc, dc;
    logic [7:0] rd;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R7 reset state
    chk(!scan_busy && !scan_done, "R1 idle after reset", scan_busy, 0);
    chk(!part0_vld && !part1_vld && !part2_vld, "R1 no valid", part1_vld, 0);
    chk(part0_off == 14'h3FFF && part1_off == 14'h3FFF && part2_off == 14'h3FFF,
        "R7 reset marker", part1_off, 'h3FFF);

    // R10 window refused while nothing found
    load(1);
    win_check(1'b0, 5, "pre-scan");
    win_check(1'b1, 5, "pre-scan");

    // R8 fixed offsets, done next cycle, no reads
    rc = rd_count;
    @(negedge clk); table_mode = 1'b0; scan_start = 1'b1;
    @(negedge clk); scan_start = 1'b0;
    chk(scan_done == 1'b1, "R8 done next cycle", scan_done, 1);
    chk(part0_off == 14'h1800 && part0_vld, "R8 part0 default", part0_off, 'h1800);
    chk(part1_off == 14'h1300 && part1_vld, "R8 part1 default", part1_off, 'h1300);
    chk(part2_off == 14'h1400 && part2_vld, "R8 part2 default", part2_off, 'h1400);
    @(negedge clk);
    chk(!scan_done && rd_count == rc, "R8 no reads / R13 pulse", rd_count, rc);

    // directed chain 1: R2, R3, R4, R5, R6
    rc = rd_count;
    @(negedge clk); table_mode = 1'b1; scan_start = 1'b1;
    @(negedge clk); scan_start = 1'b0;
    chk(scan_busy, "R13 busy after start", scan_busy, 1);
    wait_done();
    ref_walk();
    chk(rd_count - rc == 48, "R2 R3 reads of three headers", rd_count - rc, 48);
    chk(part0_vld && part0_off == 14'h10, "R4 common at 0", part0_off, 'h10);
    chk(part1_off == 14'h40 && part2_off == 14'h140, "R5 APL offsets", part1_off, 'h40);
    check_results("chain1 R6");
    @(negedge clk);
    chk(!scan_done, "R13 done is one pulse", scan_done, 0);
    // R9 / R10 bounds
    win_check(1'b0, 0, "idx0");
    win_check(1'b0, 'h100, "idx 0x100");
    win_check(1'b0, 'h101, "idx 0x101");
    win_check(1'b1, 'h100, "idx 0x100");
    win_check(1'b1, 'h200, "idx 0x200");
    win_check(1'b0, 'h100, "readback");

    // chain 2: nothing found, stops on reaching 0x2000 (R2, R7)
    load(2);
    rc = rd_count;
    do_scan(1'b1);
    ref_walk();
    chk(rd_count - rc == 32, "R2 stop at end of memory", rd_count - rc, 32);
    chk(!part0_vld && part0_off == 14'h3FFF, "R7 part0 not found", part0_off, 'h3FFF);
    check_results("chain2 R7");
    win_check(1'b0, 3, "no part1");

    // chain 3: later match wins, window wraps (R5, R9)
    load(3);
    do_scan(1'b1);
    ref_walk();
    chk(part1_off == 14'h2000 && part2_off == 14'h2100, "R5 later header wins",
        part1_off, 'h2000);
    chk(part0_off == 14'h30, "R4 common mid chain", part0_off, 'h30);
    win_check(1'b0, 7, "wrap");
    win_check(1'b1, 9, "wrap");

    // R11: start and window request in the same cycle
    load(1);
    ref_walk();
    @(negedge clk);
    table_mode = 1'b1; scan_start = 1'b1;
    win_req_valid = 1'b1; win_req_we = 1'b0; win_req_idx = 10'h20;
    #1;
    chk(win_req_ready == 1'b0, "R11 start wins over window", win_req_ready, 0);
    @(negedge clk); scan_start = 1'b0;
    chk(scan_busy, "R11 scan started", scan_busy, 1);
    #1;
    chk(!win_req_ready, "R11 window held during scan", win_req_ready, 0);
    wait_done();
    #1;
    while (!win_req_ready) begin @(negedge clk); #1; end
    @(negedge clk); win_req_valid = 1'b0;
    while (!win_rsp_valid) @(negedge clk);
    chk(win_rsp_data == mem[(e_off1 + 'h20) & MASK], "R11 held read after scan",
        win_rsp_data, mem[(e_off1 + 'h20) & MASK]);

    // R11: restart pulses during a scan are ignored
    rc = rd_count; dc = done_count;
    @(negedge clk); scan_start = 1'b1;
    @(negedge clk); scan_start = 1'b0;
    repeat (5) @(negedge clk);
    scan_start = 1'b1; @(negedge clk); scan_start = 1'b0;
    wait_done();
    repeat (3) @(negedge clk);
    chk(rd_count - rc == 48 && done_count - dc == 1, "R11 start ignored when busy",
        rd_count - rc, 48);

    // random chains
    for (int t = 0; t < 14; t++) begin
      load(0);
      ref_walk();
      rc = rd_count;
      do_scan(1'b1);
      chk(rd_count - rc == e_hdrs * 16, "R2 random header reads", rd_count - rc, e_hdrs * 16);
      check_results("random R6");
      for (int w = 0; w < 6; w++) begin
        int idx;
        idx = ($urandom % 3 == 0) ? ('h0F0 + $urandom % 40) : ($urandom % 'h400);
        win_check(1'($urandom), idx, "random");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule